// File: doc/BRIEF.md
# Joinable Transfer Buffer with Indexed Register Mode

This block sits between a host bus and one programmable I/O state machine and holds the words that pass between them. It owns two banks of four 32-bit words. In its plain configuration, one bank is a transmit queue (host pushes, state machine pulls) and the other is a receive queue (state machine pushes, host pops). A 4-bit mode input can join both banks into a single 8-deep queue for one direction. It can also turn the receive bank into four indexed registers. In that case the state machine either posts status words for the host, or reads configuration words that the host wrote, or both.

The block is built around a small configuration state machine. Its states are `ST_SPLIT`, `ST_JOIN_TX`, `ST_JOIN_RX`, `ST_REG_GET`, `ST_REG_PUT` and `ST_REG_BOTH`. There is one transition rule: whenever the decoded mode input differs from the current state, that cycle is a flush cycle. In a flush cycle every push, pop and register write is ignored and both queue pointers and levels are cleared. At the closing edge the state moves to the decoded one. Otherwise the state holds. Queue heads are first-word-fall-through, and indexed reads are combinational from the stored words.

Top module: `sm_xfer_buffer`

## Requirements
- R1: After reset the block is in `ST_SPLIT`; transmit is empty and not full, receive is empty and not full, and indexed reads return 0.
- R2: Mode 0 gives two independent 4-deep first-in-first-out queues. A push is accepted only when its queue is not full. The head word is visible on the data output while the queue is not empty. A push and a pull in the same cycle on a non-full, non-empty queue both take effect.
- R3: Mode encoding: 0 split, 1 transmit join, 2 receive join, 4 get (host writes, state machine reads), 8 put (state machine writes, host reads), 12 both. Any other value behaves as 0.
- R4: Mode 1 makes the transmit queue 8 deep. The receive side then shows empty=1 and full=1 and ignores pushes and pops.
- R5: Mode 2 makes the receive queue 8 deep. The transmit side then shows empty=1 and full=1 and ignores pushes and pulls.
- R6: In mode 4 a host indexed write stores into receive entry n (n = index 0..3). The state machine's indexed read of entry n shows that value from the next cycle on. State machine indexed writes are ignored.
- R7: In mode 8 a state machine indexed write stores into entry n and the host's indexed read returns it. Host indexed writes are ignored, and reading an entry changes nothing.
- R8: In mode 12 both sides may write and read. A read of the entry being written in the same cycle returns the old value. If both sides write the same entry in one cycle, the state machine's word is kept.
- R9: In modes 4, 8 and 12 the receive queue is disabled: receive empty reads 1, receive full reads 0, and receive pushes and pops have no effect on any entry. Outside these modes, indexed reads return 0.
- R10: A cycle in which the decoded mode differs from the current state ignores all writes, pushes and pops and empties both queues. The new mode applies from the next cycle.
- R11: A pull or pop on an empty queue is ignored and leaves the queue empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode | input | 4 | Buffer configuration code |
| h_tx_push | input | 1 | Host pushes a word into the transmit queue |
| h_tx_data | input | 32 | Word pushed by the host |
| h_tx_full | output | 1 | Transmit queue cannot accept a word |
| sm_tx_pull | input | 1 | State machine takes the transmit head |
| sm_tx_data | output | 32 | Transmit head word |
| sm_tx_empty | output | 1 | Transmit queue holds no word |
| sm_rx_push | input | 1 | State machine pushes a word into the receive queue |
| sm_rx_data | input | 32 | Word pushed by the state machine |
| sm_rx_full | output | 1 | Receive queue cannot accept a word |
| h_rx_pop | input | 1 | Host takes the receive head |
| h_rx_data | output | 32 | Receive head word |
| h_rx_empty | output | 1 | Receive queue holds no word |
| h_reg_wr | input | 1 | Host indexed write strobe |
| h_reg_idx | input | 2 | Host entry index |
| h_reg_wdata | input | 32 | Host indexed write word |
| h_reg_rdata | output | 32 | Host indexed read word |
| sm_reg_wr | input | 1 | State machine indexed write strobe |
| sm_reg_idx | input | 2 | State machine entry index |
| sm_reg_wdata | input | 32 | State machine indexed write word |
| sm_reg_rdata | output | 32 | State machine indexed read word |

## Verification
The bench targets the queue edges. It checks pushing into a full queue, pulling from an empty one, and a simultaneous push and pull. A wrong wrap point or full threshold would lose or duplicate a word, and would show full at 4 in a joined mode or at 8 in the split mode. It switches modes with data still queued, because a design that skips the flush would replay stale words. In the register modes it sends writes from the side that must be ignored, and receive pushes that would land on register entry 0. It also collides a host write with a state machine read or write on the same entry. A design with the wrong bypass or write priority would return the new word too early or keep the host's value.

// File: rtl/xbuf_pkg.sv
package xbuf_pkg;

    typedef enum logic [2:0] {
        ST_SPLIT,
        ST_JOIN_TX,
        ST_JOIN_RX,
        ST_REG_GET,
        ST_REG_PUT,
        ST_REG_BOTH
    } xbuf_state_e;

    localparam logic [3:0] MODE_SPLIT   = 4'd0;
    localparam logic [3:0] MODE_JOIN_TX = 4'd1;
    localparam logic [3:0] MODE_JOIN_RX = 4'd2;
    localparam logic [3:0] MODE_GET     = 4'd4;
    localparam logic [3:0] MODE_PUT     = 4'd8;
    localparam logic [3:0] MODE_BOTH    = 4'd12;

    function automatic xbuf_state_e decode_mode(input logic [3:0] code);
        xbuf_state_e s;
        unique case (code)
            MODE_JOIN_TX: s = ST_JOIN_TX;
            MODE_JOIN_RX: s = ST_JOIN_RX;
            MODE_GET:     s = ST_REG_GET;
            MODE_PUT:     s = ST_REG_PUT;
            MODE_BOTH:    s = ST_REG_BOTH;
            default:      s = ST_SPLIT;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/xbuf_mode_fsm.sv
module xbuf_mode_fsm
    import xbuf_pkg::*;
#(
    parameter int FIFO_DEPTH = 4,
    parameter int LW         = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [3:0]    mode_i,
    output xbuf_state_e   state_o,
    output logic          flush_o,
    output logic [LW-1:0] tx_cap_o,
    output logic [LW-1:0] rx_cap_o,
    output logic          reg_mode_o,
    output logic          host_wr_en_o,
    output logic          sm_wr_en_o
);

    localparam logic [LW-1:0] CAP_HALF = LW'(FIFO_DEPTH);
    localparam logic [LW-1:0] CAP_FULL = LW'(2 * FIFO_DEPTH);

    xbuf_state_e state_q, state_d;

    always_comb begin
        state_d = decode_mode(mode_i);
        flush_o = (state_d != state_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_SPLIT;
        else        state_q <= state_d;
    end

    always_comb begin
        tx_cap_o     = CAP_HALF;
        rx_cap_o     = CAP_HALF;
        reg_mode_o   = 1'b0;
        host_wr_en_o = 1'b0;
        sm_wr_en_o   = 1'b0;
        unique case (state_q)
            ST_SPLIT: begin
            end
            ST_JOIN_TX: begin
                tx_cap_o = CAP_FULL;
                rx_cap_o = '0;
            end
            ST_JOIN_RX: begin
                tx_cap_o = '0;
                rx_cap_o = CAP_FULL;
            end
            ST_REG_GET: begin
                rx_cap_o     = '0;
                reg_mode_o   = 1'b1;
                host_wr_en_o = 1'b1;
            end
            ST_REG_PUT: begin
                rx_cap_o   = '0;
                reg_mode_o = 1'b1;
                sm_wr_en_o = 1'b1;
            end
            ST_REG_BOTH: begin
                rx_cap_o     = '0;
                reg_mode_o   = 1'b1;
                host_wr_en_o = 1'b1;
                sm_wr_en_o   = 1'b1;
            end
            default: begin
            end
        endcase
    end

    assign state_o = state_q;

    p_state_moves_only_on_flush_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(state_q) |-> $past(flush_o));

endmodule

// File: rtl/xbuf_ptr_ctl.sv
module xbuf_ptr_ctl #(
    parameter int AW = 3,
    parameter int LW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush_i,
    input  logic [LW-1:0] cap_i,
    input  logic          push_i,
    input  logic          pop_i,
    output logic [AW-1:0] wr_slot_o,
    output logic [AW-1:0] rd_slot_o,
    output logic [LW-1:0] level_o,
    output logic          empty_o,
    output logic          full_o,
    output logic          push_ok_o,
    output logic          pop_ok_o
);

    logic [AW-1:0] wr_q, rd_q, wr_nxt, rd_nxt;
    logic [LW-1:0] lvl_q;
    logic [LW-1:0] wr_inc, rd_inc;

    always_comb begin
        empty_o   = (lvl_q == '0);
        full_o    = (lvl_q == cap_i);
        push_ok_o = push_i && !full_o && !flush_i;
        pop_ok_o  = pop_i && !empty_o && !flush_i;
        wr_inc    = LW'(wr_q) + 1'b1;
        rd_inc    = LW'(rd_q) + 1'b1;
        wr_nxt    = (wr_inc == cap_i) ? '0 : wr_inc[AW-1:0];
        rd_nxt    = (rd_inc == cap_i) ? '0 : rd_inc[AW-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q  <= '0;
            rd_q  <= '0;
            lvl_q <= '0;
        end else if (flush_i) begin
            wr_q  <= '0;
            rd_q  <= '0;
            lvl_q <= '0;
        end else begin
            if (push_ok_o) wr_q <= wr_nxt;
            if (pop_ok_o)  rd_q <= rd_nxt;
            if (push_ok_o && !pop_ok_o)      lvl_q <= lvl_q + 1'b1;
            else if (pop_ok_o && !push_ok_o) lvl_q <= lvl_q - 1'b1;
        end
    end

    assign wr_slot_o = wr_q;
    assign rd_slot_o = rd_q;
    assign level_o   = lvl_q;

    p_level_within_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        lvl_q <= cap_i);

    p_flush_empties_r10: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (lvl_q == '0));

    p_pop_empty_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && empty_o && !flush_i) |=> $stable(rd_q));

endmodule

// File: rtl/xbuf_store.sv
module xbuf_store #(
    parameter int DW    = 32,
    parameter int DEPTH = 8,
    parameter int AW    = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tx_we_i,
    input  logic [AW-1:0] tx_wa_i,
    input  logic [DW-1:0] tx_wd_i,
    input  logic          rx_we_i,
    input  logic [AW-1:0] rx_wa_i,
    input  logic [DW-1:0] rx_wd_i,
    input  logic          hr_we_i,
    input  logic [AW-1:0] hr_wa_i,
    input  logic [DW-1:0] hr_wd_i,
    input  logic          sr_we_i,
    input  logic [AW-1:0] sr_wa_i,
    input  logic [DW-1:0] sr_wd_i,
    input  logic [AW-1:0] ra_tx_i,
    input  logic [AW-1:0] ra_rx_i,
    input  logic [AW-1:0] ra_hr_i,
    input  logic [AW-1:0] ra_sr_i,
    output logic [DW-1:0] q_tx_o,
    output logic [DW-1:0] q_rx_o,
    output logic [DW-1:0] q_hr_o,
    output logic [DW-1:0] q_sr_o
);

    logic [DW-1:0] words [DEPTH];

    for (genvar e = 0; e < DEPTH; e++) begin : g_word
        logic [DW-1:0] word_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                    word_q <= '0;
            else if (sr_we_i && sr_wa_i == AW'(e))         word_q <= sr_wd_i;
            else if (hr_we_i && hr_wa_i == AW'(e))         word_q <= hr_wd_i;
            else if (rx_we_i && rx_wa_i == AW'(e))         word_q <= rx_wd_i;
            else if (tx_we_i && tx_wa_i == AW'(e))         word_q <= tx_wd_i;
        end
        assign words[e] = word_q;
    end

    assign q_tx_o = words[ra_tx_i];
    assign q_rx_o = words[ra_rx_i];
    assign q_hr_o = words[ra_hr_i];
    assign q_sr_o = words[ra_sr_i];

endmodule

// File: rtl/sm_xfer_buffer.sv
module sm_xfer_buffer
    import xbuf_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int FIFO_DEPTH = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [3:0]                    mode,
    input  logic                          h_tx_push,
    input  logic [DATA_W-1:0]             h_tx_data,
    output logic                          h_tx_full,
    input  logic                          sm_tx_pull,
    output logic [DATA_W-1:0]             sm_tx_data,
    output logic                          sm_tx_empty,
    input  logic                          sm_rx_push,
    input  logic [DATA_W-1:0]             sm_rx_data,
    output logic                          sm_rx_full,
    input  logic                          h_rx_pop,
    output logic [DATA_W-1:0]             h_rx_data,
    output logic                          h_rx_empty,
    input  logic                          h_reg_wr,
    input  logic [$clog2(FIFO_DEPTH)-1:0] h_reg_idx,
    input  logic [DATA_W-1:0]             h_reg_wdata,
    output logic [DATA_W-1:0]             h_reg_rdata,
    input  logic                          sm_reg_wr,
    input  logic [$clog2(FIFO_DEPTH)-1:0] sm_reg_idx,
    input  logic [DATA_W-1:0]             sm_reg_wdata,
    output logic [DATA_W-1:0]             sm_reg_rdata
);

    localparam int TOTAL = 2 * FIFO_DEPTH;
    localparam int AW    = $clog2(TOTAL);
    localparam int LW    = $clog2(TOTAL + 1);
    localparam logic [AW-1:0] RX_BASE = AW'(FIFO_DEPTH);

    xbuf_state_e   state;
    logic          flush, reg_mode, host_wr_en, sm_wr_en;
    logic [LW-1:0] tx_cap, rx_cap, tx_level, rx_level;
    logic [AW-1:0] tx_wr_slot, tx_rd_slot, rx_wr_slot, rx_rd_slot;
    logic          tx_empty_i, tx_full_i, rx_empty_i, rx_full_i;
    logic          tx_push_ok, tx_pop_ok, rx_push_ok, rx_pop_ok;
    logic          host_we, sm_we;
    logic [DATA_W-1:0] hr_q, sr_q;

    xbuf_mode_fsm #(.FIFO_DEPTH(FIFO_DEPTH), .LW(LW)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_i       (mode),
        .state_o      (state),
        .flush_o      (flush),
        .tx_cap_o     (tx_cap),
        .rx_cap_o     (rx_cap),
        .reg_mode_o   (reg_mode),
        .host_wr_en_o (host_wr_en),
        .sm_wr_en_o   (sm_wr_en)
    );

    xbuf_ptr_ctl #(.AW(AW), .LW(LW)) u_tx_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush_i   (flush),
        .cap_i     (tx_cap),
        .push_i    (h_tx_push),
        .pop_i     (sm_tx_pull),
        .wr_slot_o (tx_wr_slot),
        .rd_slot_o (tx_rd_slot),
        .level_o   (tx_level),
        .empty_o   (tx_empty_i),
        .full_o    (tx_full_i),
        .push_ok_o (tx_push_ok),
        .pop_ok_o  (tx_pop_ok)
    );

    xbuf_ptr_ctl #(.AW(AW), .LW(LW)) u_rx_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush_i   (flush),
        .cap_i     (rx_cap),
        .push_i    (sm_rx_push),
        .pop_i     (h_rx_pop),
        .wr_slot_o (rx_wr_slot),
        .rd_slot_o (rx_rd_slot),
        .level_o   (rx_level),
        .empty_o   (rx_empty_i),
        .full_o    (rx_full_i),
        .push_ok_o (rx_push_ok),
        .pop_ok_o  (rx_pop_ok)
    );

    assign host_we = h_reg_wr && host_wr_en && !flush;
    assign sm_we   = sm_reg_wr && sm_wr_en && !flush;

    xbuf_store #(.DW(DATA_W), .DEPTH(TOTAL), .AW(AW)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .tx_we_i (tx_push_ok),
        .tx_wa_i (tx_wr_slot),
        .tx_wd_i (h_tx_data),
        .rx_we_i (rx_push_ok),
        .rx_wa_i (rx_wr_slot + RX_BASE),
        .rx_wd_i (sm_rx_data),
        .hr_we_i (host_we),
        .hr_wa_i (RX_BASE + AW'(h_reg_idx)),
        .hr_wd_i (h_reg_wdata),
        .sr_we_i (sm_we),
        .sr_wa_i (RX_BASE + AW'(sm_reg_idx)),
        .sr_wd_i (sm_reg_wdata),
        .ra_tx_i (tx_rd_slot),
        .ra_rx_i (rx_rd_slot + RX_BASE),
        .ra_hr_i (RX_BASE + AW'(h_reg_idx)),
        .ra_sr_i (RX_BASE + AW'(sm_reg_idx)),
        .q_tx_o  (sm_tx_data),
        .q_rx_o  (h_rx_data),
        .q_hr_o  (hr_q),
        .q_sr_o  (sr_q)
    );

    always_comb begin
        h_tx_full    = tx_full_i;
        sm_tx_empty  = tx_empty_i;
        h_rx_empty   = rx_empty_i;
        sm_rx_full   = reg_mode ? 1'b0 : rx_full_i;
        h_reg_rdata  = reg_mode ? hr_q : '0;
        sm_reg_rdata = reg_mode ? sr_q : '0;
    end

    p_reg_mode_rx_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        reg_mode |-> (rx_level == '0) && !rx_pop_ok);

    p_join_rx_tx_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_JOIN_RX) |-> (tx_level == '0) && !tx_pop_ok);

    p_host_cfg_visible_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(host_we && !sm_we) && reg_mode && sm_reg_idx == $past(h_reg_idx))
            |-> sm_reg_rdata == $past(h_reg_wdata));

endmodule

// File: tb/sm_xfer_buffer_tb_top.sv
module sm_xfer_buffer_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  mode = 4'd0;
    logic        h_tx_push = 1'b0;
    logic [31:0] h_tx_data = '0;
    logic        h_tx_full;
    logic        sm_tx_pull = 1'b0;
    logic [31:0] sm_tx_data;
    logic        sm_tx_empty;
    logic        sm_rx_push = 1'b0;
    logic [31:0] sm_rx_data = '0;
    logic        sm_rx_full;
    logic        h_rx_pop = 1'b0;
    logic [31:0] h_rx_data;
    logic        h_rx_empty;
    logic        h_reg_wr = 1'b0;
    logic [1:0]  h_reg_idx = '0;
    logic [31:0] h_reg_wdata = '0;
    logic [31:0] h_reg_rdata;
    logic        sm_reg_wr = 1'b0;
    logic [1:0]  sm_reg_idx = '0;
    logic [31:0] sm_reg_wdata = '0;
    logic [31:0] sm_reg_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    sm_xfer_buffer dut_i (
        .clk(clk), .rst_n(rst_n), .mode(mode),
        .h_tx_push(h_tx_push), .h_tx_data(h_tx_data), .h_tx_full(h_tx_full),
        .sm_tx_pull(sm_tx_pull), .sm_tx_data(sm_tx_data), .sm_tx_empty(sm_tx_empty),
        .sm_rx_push(sm_rx_push), .sm_rx_data(sm_rx_data), .sm_rx_full(sm_rx_full),
        .h_rx_pop(h_rx_pop), .h_rx_data(h_rx_data), .h_rx_empty(h_rx_empty),
        .h_reg_wr(h_reg_wr), .h_reg_idx(h_reg_idx), .h_reg_wdata(h_reg_wdata),
        .h_reg_rdata(h_reg_rdata),
        .sm_reg_wr(sm_reg_wr), .sm_reg_idx(sm_reg_idx), .sm_reg_wdata(sm_reg_wdata),
        .sm_reg_rdata(sm_reg_rdata)
    );

    typedef struct packed {
        logic        push;
        logic        pull;
        logic [31:0] din;
        logic        x_full;
        logic        x_empty;
        logic [31:0] x_head;
    } vec_t;

    // R2 / R11: split-mode transmit queue walk
    localparam vec_t VECS [12] = '{
        '{1'b1, 1'b0, 32'hA1, 1'b0, 1'b0, 32'hA1},
        '{1'b1, 1'b0, 32'hA2, 1'b0, 1'b0, 32'hA1},
        '{1'b1, 1'b0, 32'hA3, 1'b0, 1'b0, 32'hA1},
        '{1'b1, 1'b0, 32'hA4, 1'b1, 1'b0, 32'hA1},
        '{1'b1, 1'b0, 32'hA5, 1'b1, 1'b0, 32'hA1},
        '{1'b0, 1'b1, 32'h00, 1'b0, 1'b0, 32'hA2},
        '{1'b1, 1'b1, 32'hA6, 1'b0, 1'b0, 32'hA3},
        '{1'b0, 1'b1, 32'h00, 1'b0, 1'b0, 32'hA4},
        '{1'b0, 1'b1, 32'h00, 1'b0, 1'b0, 32'hA6},
        '{1'b0, 1'b1, 32'h00, 1'b0, 1'b1, 32'h00},
        '{1'b0, 1'b1, 32'h00, 1'b0, 1'b1, 32'h00},
        '{1'b1, 1'b0, 32'hA7, 1'b0, 1'b0, 32'hA7}
    };

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic set_mode(input logic [3:0] m);
        mode = m;
        tick();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1 tx empty", 32'(sm_tx_empty), 32'd1);
        chk("R1 tx full", 32'(h_tx_full), 32'd0);
        chk("R1 rx empty", 32'(h_rx_empty), 32'd1);
        chk("R1 rx full", 32'(sm_rx_full), 32'd0);
        chk("R1 reg read", h_reg_rdata, 32'd0);

        // R2 / R11 vector walk
        for (int i = 0; i < 12; i++) begin
            h_tx_push  = VECS[i].push;
            h_tx_data  = VECS[i].din;
            sm_tx_pull = VECS[i].pull;
            tick();
            h_tx_push  = 1'b0;
            sm_tx_pull = 1'b0;
            #1;
            chk("R2/R11 tx full", 32'(h_tx_full), 32'(VECS[i].x_full));
            chk("R2/R11 tx empty", 32'(sm_tx_empty), 32'(VECS[i].x_empty));
            if (!VECS[i].x_empty) chk("R2 tx head", sm_tx_data, VECS[i].x_head);
        end

        // R2 receive queue, independent of transmit
        for (int i = 0; i < 5; i++) begin
            sm_rx_push = 1'b1;
            sm_rx_data = 32'hB0 + 32'(i);
            tick();
        end
        sm_rx_push = 1'b0;
        #1;
        chk("R2 rx full at 4", 32'(sm_rx_full), 32'd1);
        chk("R2 tx untouched", sm_tx_data, 32'hA7);
        for (int i = 0; i < 4; i++) begin
            chk("R2 rx order", h_rx_data, 32'hB0 + 32'(i));
            h_rx_pop = 1'b1;
            tick();
            h_rx_pop = 1'b0;
        end
        chk("R2 rx empty", 32'(h_rx_empty), 32'd1);

        // R10 flush on mode change to transmit join
        set_mode(4'd1);
        chk("R10 tx flushed", 32'(sm_tx_empty), 32'd1);
        chk("R4 rx empty", 32'(h_rx_empty), 32'd1);
        chk("R4 rx full", 32'(sm_rx_full), 32'd1);

        // R4 eight-deep transmit
        for (int i = 0; i < 8; i++) begin
            if (i == 7) chk("R4 not full at 7", 32'(h_tx_full), 32'd0);
            h_tx_push = 1'b1;
            h_tx_data = 32'hC0 + 32'(i);
            sm_rx_push = 1'b1;
            sm_rx_data = 32'hDEAD;
            tick();
        end
        h_tx_push = 1'b0;
        sm_rx_push = 1'b0;
        #1;
        chk("R4 full at 8", 32'(h_tx_full), 32'd1);
        chk("R4 rx ignores push", 32'(h_rx_empty), 32'd1);
        for (int i = 0; i < 8; i++) begin
            chk("R4 tx order", sm_tx_data, 32'hC0 + 32'(i));
            sm_tx_pull = 1'b1;
            tick();
            sm_tx_pull = 1'b0;
        end
        chk("R4 drained", 32'(sm_tx_empty), 32'd1);

        // R5 eight-deep receive
        set_mode(4'd2);
        chk("R5 tx empty", 32'(sm_tx_empty), 32'd1);
        chk("R5 tx full", 32'(h_tx_full), 32'd1);
        for (int i = 0; i < 8; i++) begin
            if (i == 7) chk("R5 not full at 7", 32'(sm_rx_full), 32'd0);
            sm_rx_push = 1'b1;
            sm_rx_data = 32'hD0 + 32'(i);
            h_tx_push = 1'b1;
            tick();
        end
        sm_rx_push = 1'b0;
        h_tx_push = 1'b0;
        #1;
        chk("R5 full at 8", 32'(sm_rx_full), 32'd1);
        chk("R5 tx ignores push", 32'(sm_tx_empty), 32'd1);
        for (int i = 0; i < 8; i++) begin
            chk("R5 rx order", h_rx_data, 32'hD0 + 32'(i));
            h_rx_pop = 1'b1;
            tick();
            h_rx_pop = 1'b0;
        end
        chk("R5 drained", 32'(h_rx_empty), 32'd1);

        // R3 unlisted code behaves as split: transmit full at 4
        set_mode(4'd3);
        for (int i = 0; i < 4; i++) begin
            h_tx_push = 1'b1;
            h_tx_data = 32'hE0 + 32'(i);
            tick();
        end
        h_tx_push = 1'b0;
        #1;
        chk("R3 code 3 full at 4", 32'(h_tx_full), 32'd1);

        // R6 get mode
        set_mode(4'd4);
        chk("R10 tx flushed again", 32'(sm_tx_empty), 32'd1);
        for (int i = 0; i < 4; i++) begin
            h_reg_wr = 1'b1;
            h_reg_idx = 2'(i);
            h_reg_wdata = 32'h1000 + 32'(i);
            tick();
        end
        h_reg_wr = 1'b0;
        for (int i = 0; i < 4; i++) begin
            sm_reg_idx = 2'(i);
            #1;
            chk("R6 sm reads cfg", sm_reg_rdata, 32'h1000 + 32'(i));
        end
        sm_reg_wr = 1'b1;
        sm_reg_idx = 2'd1;
        sm_reg_wdata = 32'hBAD;
        tick();
        sm_reg_wr = 1'b0;
        #1;
        chk("R6 sm write ignored", sm_reg_rdata, 32'h1001);
        // R9 receive path disabled
        chk("R9 rx empty", 32'(h_rx_empty), 32'd1);
        chk("R9 rx not full", 32'(sm_rx_full), 32'd0);
        sm_rx_push = 1'b1;
        sm_rx_data = 32'hF00D;
        tick();
        sm_rx_push = 1'b0;
        sm_reg_idx = 2'd0;
        #1;
        chk("R9 push leaves entry 0", sm_reg_rdata, 32'h1000);
        chk("R9 rx still empty", 32'(h_rx_empty), 32'd1);

        // R7 put mode
        set_mode(4'd8);
        for (int i = 0; i < 4; i++) begin
            sm_reg_wr = 1'b1;
            sm_reg_idx = 2'(i);
            sm_reg_wdata = 32'h2000 + 32'(i);
            tick();
        end
        sm_reg_wr = 1'b0;
        for (int i = 0; i < 4; i++) begin
            h_reg_idx = 2'(i);
            #1;
            chk("R7 host reads status", h_reg_rdata, 32'h2000 + 32'(i));
        end
        h_reg_wr = 1'b1;
        h_reg_idx = 2'd2;
        h_reg_wdata = 32'hBAD;
        h_rx_pop = 1'b1;
        tick();
        h_reg_wr = 1'b0;
        h_rx_pop = 1'b0;
        #1;
        chk("R7 host write ignored", h_reg_rdata, 32'h2002);
        h_reg_idx = 2'd0;
        tick();
        chk("R7 read repeatable", h_reg_rdata, 32'h2000);

        // R8 both directions
        set_mode(4'd12);
        h_reg_wr = 1'b1;
        h_reg_idx = 2'd2;
        h_reg_wdata = 32'h3002;
        tick();
        h_reg_wdata = 32'h3102;
        sm_reg_idx = 2'd2;
        #1;
        chk("R8 same-cycle read old", sm_reg_rdata, 32'h3002);
        tick();
        h_reg_wr = 1'b0;
        #1;
        chk("R8 read new next cycle", sm_reg_rdata, 32'h3102);
        h_reg_wr = 1'b1;
        h_reg_idx = 2'd1;
        h_reg_wdata = 32'h4444;
        sm_reg_wr = 1'b1;
        sm_reg_idx = 2'd1;
        sm_reg_wdata = 32'h5555;
        tick();
        h_reg_wr = 1'b0;
        sm_reg_wr = 1'b0;
        #1;
        chk("R8 sm write wins", h_reg_rdata, 32'h5555);

        // R9 indexed read zero outside register modes
        set_mode(4'd0);
        chk("R9 read zero in split", h_reg_rdata, 32'd0);
        chk("R9 sm read zero in split", sm_reg_rdata, 32'd0);

        finish_run();
    end

endmodule